// File: doc/BRIEF.md
# Packed-Index Instruction Decompressor

This block sits on the fetch path between a 32-bit processor and an instruction cache that stores compressed code. Every word read from the cache is one of two kinds. A normal instruction goes to the processor unchanged. A packed word carries two to four small indices into a 256-entry instruction dictionary. The block keeps a packed word in an internal buffer. It then issues one expanded instruction per cycle, reading each one from the dictionary. It fetches the next cache word only once the last index has been consumed, so one cache read can feed up to four instructions.

A packed word is recognised by an opcode pattern that is illegal as a real instruction. The rest of its top byte gives three things: the slot width, whether the last slot holds a branch displacement instead of an index, and a start position used when a branch lands inside the word. A dictionary entry flagged as a branch keeps only its upper 10 opcode bits. The 22-bit displacement is rebuilt from the word's displacement slot by sign extension. The processor redirects the block with an address and a flag that marks a branch target. If the redirect targets the packed word already in the buffer, no cache access is made.

The dictionary is loaded through its write port before the first redirect starts fetching.

Top module: `dict_decomp`

## Requirements
- R1: After reset, and after a reset applied while the block is running, `insn_valid` and `cache_req` stay low until the next `redirect`. The packed-word buffer is also emptied, so the next redirect reads the cache.
- R2: A cache word is treated as packed only when bits [31:30] are 00 and bits [25:24] are 00. Any other word is issued once, unchanged, as a single instruction. This holds even when the target flag is set.
- R3: With bit 29 = 0 and bit 28 = 0, the word holds four 6-bit indices, zero-extended, in [23:18], [17:12], [11:6] and [5:0]. They are issued in that order.
- R4: With bit 29 = 1 and bit 28 = 0, the word holds three 8-bit indices in [23:16], [15:8] and [7:0]. They are issued in that order and reach every dictionary entry.
- R5: With bit 28 = 1, the last slot holds a branch displacement rather than an index. With 6-bit slots this gives three indices and a displacement in [5:0]. With 8-bit slots it gives two indices and a displacement in [7:0].
- R6: When a dictionary entry has bit 32 set, the issued instruction is the entry's bits [31:22] followed by the displacement slot sign-extended to 22 bits. Otherwise it is entry bits [31:0].
- R7: When `redirect_tgt` is set, expansion starts at the index selected by bits [27:26] (0 = first). When it is clear, expansion starts at the first index and those bits are ignored.
- R8: After the last index of a packed word is accepted, the block requests address + 1 from the cache. A packed word costs exactly one cache read.
- R9: A redirect with `redirect_tgt` set to the address of the buffered packed word makes no cache read, and the target instruction is valid in the next cycle. Any other redirect fetches from the cache, so its first instruction arrives one cycle later when the cache answers at once.
- R10: While `insn_ready` is low, `insn_valid` and `insn_data` hold. While the cache has not answered, `cache_req` and `cache_addr` hold.
- R11: A `redirect` takes priority. The instruction offered in that cycle, and any cache response in that cycle, are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dict_we | input | 1 | Dictionary write strobe |
| dict_waddr | input | 8 | Dictionary write index |
| dict_wdata | input | 33 | Dictionary entry: bit 32 branch flag, bits 31:0 instruction |
| redirect | input | 1 | Processor changes fetch address |
| redirect_addr | input | ADDR_W | New word address |
| redirect_tgt | input | 1 | Redirect is a branch target, so the start field applies |
| insn_valid | output | 1 | Instruction offered to processor |
| insn_ready | input | 1 | Processor accepts the offered instruction |
| insn_data | output | 32 | Instruction to processor |
| cache_req | output | 1 | Cache read request, held until answered |
| cache_addr | output | ADDR_W | Word address being read |
| cache_rvalid | input | 1 | Cache answers the current address |
| cache_rdata | input | 32 | Cache word |

## Verification
A vector table drives each of the four packed layouts, plain words whose top byte almost matches the escape pattern, and packed words entered with and without the target flag. The table shows that the slot width, the branch-slot flag and the start field are decoded independently. Branch dictionary entries are read with both a negative 6-bit and a negative 8-bit displacement, and one entry has junk in its low bits, so sign extension and the dropping of stored low bits are both seen. Directed cases compare the latency and cache-read count of a redirect that hits the buffer against one that misses. They also cover redirects that discard a pending instruction, a processor stall in the middle of a word, a slow cache, and a reset while running.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned IDX_W      = 8;
    localparam int unsigned DICT_W     = WORD_W + 1;
    localparam int unsigned MAX_SLOTS  = 4;
    localparam int unsigned PAYLOAD_W  = 24;
    localparam int unsigned NARROW_W   = 6;
    localparam int unsigned WIDE_W     = 8;
    localparam int unsigned WIDE_SLOTS = PAYLOAD_W / WIDE_W;
    localparam int unsigned DISP_W     = 22;
    localparam int unsigned UPPER_W    = WORD_W - DISP_W;
    localparam int unsigned CNT_W      = 3;
    localparam int unsigned SLOT_W     = 2;
    // escape byte field positions
    localparam int unsigned WIDE_BIT   = 29;
    localparam int unsigned BR_BIT     = 28;
    localparam int unsigned TT_LO      = 26;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_PLAIN  = 2'd2,
        ST_EXPAND = 2'd3
    } dstate_e;
endpackage

// File: rtl/pkt_decode.sv
module pkt_decode
    import dcmp_pkg::*;
(
    input  logic [WORD_W-1:0]                   word,
    output logic                                is_packed,
    output logic [CNT_W-1:0]                    count,
    output logic [SLOT_W-1:0]                   tt,
    output logic [MAX_SLOTS-1:0][IDX_W-1:0]     idx,
    output logic [DISP_W-1:0]                   disp
);
    logic wide;
    logic has_br;

    // illegal-opcode signature: major op 00, minor op 00
    assign is_packed = (word[31:30] == 2'b00) && (word[25:24] == 2'b00);
    assign wide      = word[WIDE_BIT];
    assign has_br    = word[BR_BIT];
    assign tt        = word[TT_LO +: SLOT_W];

    always_comb begin
        case ({wide, has_br})
            2'b00:   count = CNT_W'(MAX_SLOTS);
            2'b11:   count = CNT_W'(WIDE_SLOTS - 1);
            default: count = CNT_W'(WIDE_SLOTS);
        endcase
    end

    // slot 0 sits at the top of the payload
    for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_slot
        localparam int unsigned NLO = PAYLOAD_W - NARROW_W * (k + 1);
        logic [IDX_W-1:0] n_idx;
        logic [IDX_W-1:0] w_idx;
        assign n_idx = IDX_W'(word[NLO +: NARROW_W]);
        if (k < WIDE_SLOTS) begin : g_wide
            assign w_idx = word[PAYLOAD_W - WIDE_W * (k + 1) +: WIDE_W];
        end else begin : g_none
            assign w_idx = '0;
        end
        assign idx[k] = wide ? w_idx : n_idx;
    end

    // displacement always lives in the last slot
    assign disp = wide ? {{(DISP_W-WIDE_W){word[WIDE_W-1]}},     word[WIDE_W-1:0]}
                       : {{(DISP_W-NARROW_W){word[NARROW_W-1]}}, word[NARROW_W-1:0]};
endmodule

// File: rtl/dict_ram.sv
module dict_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 33
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/insn_expand.sv
module insn_expand
    import dcmp_pkg::*;
(
    input  logic [DICT_W-1:0] entry,
    input  logic [DISP_W-1:0] disp,
    output logic [WORD_W-1:0] insn
);
    logic is_branch;
    assign is_branch = entry[DICT_W-1];
    assign insn = is_branch ? {entry[WORD_W-1 -: UPPER_W], disp} : entry[WORD_W-1:0];
endmodule

// File: rtl/dict_decomp.sv
module dict_decomp
    import dcmp_pkg::*;
#(
    parameter int unsigned ADDR_W = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dict_we,
    input  logic [IDX_W-1:0]    dict_waddr,
    input  logic [DICT_W-1:0]   dict_wdata,
    input  logic                redirect,
    input  logic [ADDR_W-1:0]   redirect_addr,
    input  logic                redirect_tgt,
    output logic                insn_valid,
    input  logic                insn_ready,
    output logic [WORD_W-1:0]   insn_data,
    output logic                cache_req,
    output logic [ADDR_W-1:0]   cache_addr,
    input  logic                cache_rvalid,
    input  logic [WORD_W-1:0]   cache_rdata
);
    typedef struct packed {
        dstate_e                             st;
        logic [ADDR_W-1:0]                   addr;
        logic                                tgt;
        logic [WORD_W-1:0]                   plain;
        logic                                pk;
        logic [ADDR_W-1:0]                   pk_addr;
        logic [SLOT_W-1:0]                   slot;
        logic [CNT_W-1:0]                    cnt;
        logic [SLOT_W-1:0]                   tt;
        logic [MAX_SLOTS-1:0][IDX_W-1:0]     idx;
        logic [DISP_W-1:0]                   off;
    } regs_t;

    regs_t q, d;

    logic                             n_packed;
    logic [CNT_W-1:0]                 n_count;
    logic [SLOT_W-1:0]                n_tt;
    logic [MAX_SLOTS-1:0][IDX_W-1:0]  n_idx;
    logic [DISP_W-1:0]                n_disp;
    logic [SLOT_W-1:0]                new_start;
    logic                             last_slot;
    logic                             hit;
    logic [IDX_W-1:0]                 dict_raddr;
    logic [DICT_W-1:0]                dict_rdata;
    logic [WORD_W-1:0]                exp_insn;

    pkt_decode u_dec (
        .word      (cache_rdata),
        .is_packed (n_packed),
        .count     (n_count),
        .tt        (n_tt),
        .idx       (n_idx),
        .disp      (n_disp)
    );

    dict_ram #(.AW(IDX_W), .DW(DICT_W)) u_dict (
        .clk   (clk),
        .we    (dict_we),
        .waddr (dict_waddr),
        .wdata (dict_wdata),
        .raddr (dict_raddr),
        .rdata (dict_rdata)
    );

    insn_expand u_exp (
        .entry (dict_rdata),
        .disp  (q.off),
        .insn  (exp_insn)
    );

    assign cache_addr = q.addr;

    always_comb begin
        d          = q;
        cache_req  = 1'b0;
        insn_valid = 1'b0;
        insn_data  = '0;
        new_start  = q.tgt ? n_tt : '0;
        last_slot  = ({1'b0, q.slot} + CNT_W'(1)) >= q.cnt;
        hit        = q.pk && redirect_tgt && (redirect_addr == q.pk_addr)
                     && ({1'b0, q.tt} < q.cnt);

        case (q.st)
            ST_FETCH: begin
                cache_req = 1'b1;
                if (cache_rvalid) begin
                    d.plain = cache_rdata;
                    if (!n_packed) begin
                        d.pk = 1'b0;
                        d.st = ST_PLAIN;
                    end else begin
                        d.pk      = 1'b1;
                        d.pk_addr = q.addr;
                        d.cnt     = n_count;
                        d.tt      = n_tt;
                        d.idx     = n_idx;
                        d.off     = n_disp;
                        if ({1'b0, new_start} < n_count) begin
                            d.slot = new_start;
                            d.st   = ST_EXPAND;
                        end else begin
                            d.addr = q.addr + ADDR_W'(1);
                            d.tgt  = 1'b0;
                        end
                    end
                end
            end
            ST_PLAIN: begin
                insn_valid = 1'b1;
                insn_data  = q.plain;
                if (insn_ready) begin
                    d.addr = q.addr + ADDR_W'(1);
                    d.tgt  = 1'b0;
                    d.st   = ST_FETCH;
                end
            end
            ST_EXPAND: begin
                insn_valid = 1'b1;
                insn_data  = exp_insn;
                if (insn_ready) begin
                    if (!last_slot) begin
                        d.slot = q.slot + SLOT_W'(1);
                    end else begin
                        d.addr = q.addr + ADDR_W'(1);
                        d.tgt  = 1'b0;
                        d.st   = ST_FETCH;
                    end
                end
            end
            default: begin
            end
        endcase

        // redirect overrides every update above
        if (redirect) begin
            d      = q;
            d.addr = redirect_addr;
            d.tgt  = redirect_tgt;
            if (hit) begin
                d.slot = q.tt;
                d.st   = ST_EXPAND;
            end else begin
                d.st   = ST_FETCH;
            end
        end

        dict_raddr = d.idx[d.slot];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !insn_ready && !redirect && !dict_we) |=> (insn_valid && $stable(insn_data)));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req && !cache_rvalid && !redirect) |=> (cache_req && $stable(cache_addr)));

    // R8
    seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXPAND && insn_ready && last_slot && !redirect)
        |=> (cache_req && cache_addr == $past(cache_addr) + ADDR_W'(1)));

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXPAND) |-> ({1'b0, q.slot} < q.cnt));

    // R9
    hit_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && hit) |=> (insn_valid && !cache_req));
endmodule

// File: tb/dict_decomp_tb.sv
module dict_decomp_tb;
    localparam int ADDR_W = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dict_we = 1'b0;
    logic [7:0]        dict_waddr = '0;
    logic [32:0]       dict_wdata = '0;
    logic              redirect = 1'b0;
    logic [ADDR_W-1:0] redirect_addr = '0;
    logic              redirect_tgt = 1'b0;
    logic              insn_valid;
    logic              insn_ready = 1'b1;
    logic [31:0]       insn_data;
    logic              cache_req;
    logic [ADDR_W-1:0] cache_addr;
    logic              cache_rvalid = 1'b0;
    logic [31:0]       cache_rdata = '0;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int lat    = 0;

    logic [31:0]       cmem [256];
    logic              seen_v = 1'b0;
    logic [ADDR_W-1:0] seen_addr = '0;
    int                wcnt = 0;

    always #5 clk = ~clk;

    dict_decomp #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dict_we(dict_we), .dict_waddr(dict_waddr), .dict_wdata(dict_wdata),
        .redirect(redirect), .redirect_addr(redirect_addr), .redirect_tgt(redirect_tgt),
        .insn_valid(insn_valid), .insn_ready(insn_ready), .insn_data(insn_data),
        .cache_req(cache_req), .cache_addr(cache_addr),
        .cache_rvalid(cache_rvalid), .cache_rdata(cache_rdata)
    );

    // cache model: answers after lat waiting cycles on a stable address
    always @(negedge clk) begin
        if (cache_req && seen_v && cache_addr == seen_addr) wcnt = wcnt + 1;
        else wcnt = 0;
        seen_v       = cache_req;
        seen_addr    = cache_addr;
        cache_rvalid = cache_req && (wcnt >= lat);
        cache_rdata  = cache_req ? cmem[cache_addr[7:0]] : 32'h0;
    end

    always @(posedge clk) begin
        if (rst_n && cache_req && cache_rvalid && !redirect) reads <= reads + 1;
    end

    typedef struct packed {
        logic [31:0] word;
        logic        tgt;
        logic [2:0]  n;
        logic [31:0] e0;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [31:0] e3;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{32'h000420FF, 1'b0, 3'd4, 32'hC0000001, 32'hC0000002, 32'hC0000003, 32'hC000003F}, // R3
        '{32'h20FF8007, 1'b0, 3'd3, 32'hC00000FF, 32'hC0000080, 32'hC0000007, 32'h0},        // R4
        '{32'h101051BE, 1'b0, 3'd3, 32'hC0000004, 32'h10BFFFFE, 32'hC0000006, 32'h0},        // R5 R6
        '{32'h30C80980, 1'b0, 3'd2, 32'h403FFF80, 32'hC0000009, 32'h0, 32'h0},               // R5 R6
        '{32'h30050305, 1'b0, 3'd2, 32'h10800005, 32'hC0000003, 32'h0, 32'h0},               // R6
        '{32'h080420FF, 1'b1, 3'd2, 32'hC0000003, 32'hC000003F, 32'h0, 32'h0},               // R7
        '{32'h080420FF, 1'b0, 3'd4, 32'hC0000001, 32'hC0000002, 32'hC0000003, 32'hC000003F}, // R7
        '{32'h82000001, 1'b1, 3'd1, 32'h82000001, 32'h0, 32'h0, 32'h0},                      // R2
        '{32'h01001234, 1'b0, 3'd1, 32'h01001234, 32'h0, 32'h0, 32'h0},                      // R2
        '{32'h34C80980, 1'b1, 3'd1, 32'hC0000009, 32'h0, 32'h0, 32'h0}                       // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_redirect(input logic [ADDR_W-1:0] a, input logic t);
        redirect      = 1'b1;
        redirect_addr = a;
        redirect_tgt  = t;
        @(negedge clk);
        redirect      = 1'b0;
        redirect_tgt  = 1'b0;
    endtask

    task automatic get_insn(output logic [31:0] dat, output int w);
        w = 1;
        while (!insn_valid) begin
            @(negedge clk);
            w++;
        end
        dat = insn_data;
        @(negedge clk);
    endtask

    function automatic logic [32:0] dict_val(input int i);
        if (i == 5)   return {1'b1, 32'h10800000};
        if (i == 200) return {1'b1, 32'h40001234};
        return {1'b0, 32'hC0000000 | 32'(i)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] got;
        int          w;
        int          r0;
        for (int i = 0; i < 256; i++) cmem[i] = 32'hF0000000 | 32'(i);

        repeat (3) @(negedge clk);
        // R1: idle out of reset
        chk("R1 valid in reset", {31'b0, insn_valid}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (i == 0) chk("R1 req after reset", {31'b0, cache_req}, 32'h0);
            dict_we    = 1'b1;
            dict_waddr = 8'(i);
            dict_wdata = dict_val(i);
        end
        @(negedge clk);
        dict_we = 1'b0;
        chk("R1 valid idle", {31'b0, insn_valid}, 32'h0);
        chk("R1 req idle", {31'b0, cache_req}, 32'h0);

        // table walk: every layout, start field, plain words, sequential advance (R8)
        for (int r = 0; r < NV; r++) begin
            int base;
            base = 8 + 4 * r;
            cmem[base]     = VEC[r].word;
            cmem[base + 1] = 32'hF0000000 | 32'(base + 1);
            r0 = reads;
            do_redirect(ADDR_W'(base), VEC[r].tgt);
            for (int j = 0; j < int'(VEC[r].n); j++) begin
                logic [31:0] e;
                e = (j == 0) ? VEC[r].e0 : (j == 1) ? VEC[r].e1 : (j == 2) ? VEC[r].e2 : VEC[r].e3;
                get_insn(got, w);
                chk($sformatf("R3-7 row%0d slot%0d", r, j), got, e);
            end
            get_insn(got, w);
            chk($sformatf("R8 next word row%0d", r), got, 32'hF0000000 | 32'(base + 1));
            chk($sformatf("R8 reads row%0d", r), 32'(reads - r0), 32'd2);
        end

        // R9 and R11: miss latency, then in-buffer target drops pending insn
        cmem[100] = 32'h080420FF;
        do_redirect(ADDR_W'(100), 1'b0);
        get_insn(got, w);
        chk("R9 miss data", got, 32'hC0000001);
        chk("R9 miss latency", 32'(w), 32'd2);
        r0 = reads;
        do_redirect(ADDR_W'(100), 1'b1);
        get_insn(got, w);
        chk("R11 R9 hit data", got, 32'hC0000003);
        chk("R9 hit latency", 32'(w), 32'd1);
        chk("R9 hit no read", 32'(reads - r0), 32'd0);
        get_insn(got, w);
        chk("R9 hit tail", got, 32'hC000003F);

        // R11: redirect away mid-word
        cmem[120] = 32'h000420FF;
        cmem[124] = 32'h20FF8007;
        do_redirect(ADDR_W'(120), 1'b0);
        get_insn(got, w);
        chk("R11 first", got, 32'hC0000001);
        do_redirect(ADDR_W'(124), 1'b0);
        get_insn(got, w);
        chk("R11 new target", got, 32'hC00000FF);

        // R10: processor stall mid-word
        cmem[130] = 32'h000420FF;
        do_redirect(ADDR_W'(130), 1'b0);
        get_insn(got, w);
        insn_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R10 stall valid", {31'b0, insn_valid}, 32'h1);
            chk("R10 stall data", insn_data, 32'hC0000002);
            @(negedge clk);
        end
        insn_ready = 1'b1;
        get_insn(got, w);
        chk("R10 resume", got, 32'hC0000002);
        get_insn(got, w);
        chk("R10 next", got, 32'hC0000003);

        // R10: slow cache
        lat = 3;
        cmem[140] = 32'h82000002;
        do_redirect(ADDR_W'(140), 1'b0);
        chk("R10 req held", {31'b0, cache_req}, 32'h1);
        get_insn(got, w);
        chk("R10 slow data", got, 32'h82000002);
        chk("R10 slow latency", 32'(w), 32'd5);
        lat = 0;

        // R1: reset while running clears buffer
        cmem[150] = 32'h000420FF;
        do_redirect(ADDR_W'(150), 1'b0);
        get_insn(got, w);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 valid in mid reset", {31'b0, insn_valid}, 32'h0);
        chk("R1 req in mid reset", {31'b0, cache_req}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after mid reset", {30'b0, insn_valid, cache_req}, 32'h0);
        r0 = reads;
        do_redirect(ADDR_W'(150), 1'b1);
        get_insn(got, w);
        chk("R1 buffer cleared data", got, 32'hC0000001);
        chk("R1 buffer cleared read", 32'(reads - r0), 32'd1);
        chk("R1 buffer cleared latency", 32'(w), 32'd2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule